// File: doc/BRIEF.md
# Two-Cycle BCD Accumulator Processor Core

This block is a small one-address processor built around a single accumulator. Every data word and instruction is three decimal digits, each digit held as a 4-bit BCD nibble. Its private memory has one hundred words, with addresses 00 to 99 written as two BCD digits.

Each instruction takes exactly two clock cycles. In the first cycle the word at the program counter is latched into the instruction register. In the second cycle the instruction register alone selects the action. A memory-referencing instruction places its two address digits on the memory address. Every register change, including a memory write, lands on the clock edge that closes the execute cycle.

A test port writes and reads the memory directly. It is used to load programs and data while the core is held in reset, and to inspect memory afterwards. The program counter, instruction register, accumulator and a halted flag are visible at the ports.

Top module: `acc_cpu_top`

## Requirements
- R1: An instruction word d2 d1 d0 (d2 in bits 11:8, d0 in bits 3:0) whose top digit is nonzero is an address instruction: d2 is the opcode and d1 d0 (bits 7:0) is the operand address. A word whose top digit is zero carries no address.
- R2: After reset is released, instructions run as strict fetch/execute pairs. The program counter changes only on the edge that ends an execute cycle, and a four-instruction program ending in halt raises halted_o on the 8th rising edge.
- R3: Opcode 1 (load) copies the addressed memory word into the accumulator.
- R4: Opcode 2 (store) writes the accumulator into the addressed word at the end of the execute cycle.
- R5: Opcode 3 (add) replaces the accumulator with accumulator plus memory word, in BCD, modulo 1000.
- R6: Opcode 4 (subtract) replaces the accumulator with accumulator minus memory word, in BCD, modulo 1000, so a negative result wraps (003 - 005 = 998).
- R7: Opcode 5 (jump) loads the address digits into the program counter, and a skipped instruction has no effect. Every other non-halting instruction advances the program counter by one in BCD, with 99 wrapping to 00.
- R8: The word 000 is halt. It raises halted_o at the end of its execute cycle and freezes the program counter (left at the halt's address), the accumulator and the instruction register until reset.
- R9: Opcodes 6 to 9, and no-address words other than 000, change only the program counter, which advances by one.
- R10: While rst_ni is low, pc_o, acc_o, ir_o and halted_o read zero. Memory contents are not affected by reset.
- R11: The test port writes tl_wdata_i to address tl_addr_i on a rising edge when tl_we_i is high, and tl_rdata_o shows that word combinationally. An address with a digit above 9 is ignored on write and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the core |
| tl_we_i | input | 1 | Test port write enable |
| tl_addr_i | input | 8 | Test port address, two BCD digits |
| tl_wdata_i | input | 12 | Test port write data, three BCD digits |
| tl_rdata_o | output | 12 | Test port read data |
| pc_o | output | 8 | Program counter |
| ir_o | output | 12 | Instruction register |
| acc_o | output | 12 | Accumulator |
| halted_o | output | 1 | High once a halt instruction has executed |

## Verification
A sequencer that slips out of its fetch/execute alternation changes the cycle count to halted_o, and the count is checked against exactly eight edges. A bad decode or BCD correction shows in acc_o at halt and in the stored result word, which is read through the test port one instruction later. A broken increment or jump shows as a wrong pc_o within two cycles. Wrap at 99 and freeze after halt are observed directly on pc_o.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  localparam int DIGITS      = 3;
  localparam int W           = 4 * DIGITS;
  localparam int ADDR_DIGITS = 2;
  localparam int AW          = 4 * ADDR_DIGITS;
  localparam int MEM_WORDS   = 10 ** ADDR_DIGITS;

  typedef enum logic {ST_FETCH, ST_EXEC} state_e;

  localparam logic [3:0] OP_LOAD  = 4'd1;
  localparam logic [3:0] OP_STORE = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;
  localparam logic [3:0] OP_SUB   = 4'd4;
  localparam logic [3:0] OP_JUMP  = 4'd5;

  function automatic logic addr_is_bcd(input logic [AW-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ADDR_DIGITS; i++)
      if (a[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int N = 3
) (
  input  logic [4*N-1:0] a_i,
  input  logic [4*N-1:0] b_i,
  input  logic           sub_i,
  output logic [4*N-1:0] sum_o
);
  logic [N:0] c;
  assign c[0] = sub_i;  // +1 completes nines' complement

  for (genvar g = 0; g < N; g++) begin : g_dig
    logic [3:0] bd;
    logic [4:0] s;
    assign bd       = sub_i ? 4'd9 - b_i[4*g +: 4] : b_i[4*g +: 4];
    assign s        = {1'b0, a_i[4*g +: 4]} + {1'b0, bd} + {4'b0, c[g]};
    assign c[g+1]   = s > 5'd9;
    assign sum_o[4*g +: 4] = c[g+1] ? 4'(s - 5'd10) : s[3:0];
  end
endmodule

// File: rtl/bcd_ram.sv
module bcd_ram #(
  parameter int W     = 12,
  parameter int AW    = 8,
  parameter int WORDS = 100
) (
  input  logic          clk_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_we_i,
  input  logic [W-1:0]  cpu_wdata_i,
  output logic [W-1:0]  cpu_rdata_o,
  input  logic          tl_we_i,
  input  logic [AW-1:0] tl_addr_i,
  input  logic [W-1:0]  tl_wdata_i,
  output logic [W-1:0]  tl_rdata_o
);
  localparam int ND = AW / 4;
  localparam int IW = $clog2(WORDS);

  logic [W-1:0] mem [WORDS];

  function automatic logic [IW-1:0] to_index(input logic [AW-1:0] a);
    int idx;
    idx = 0;
    for (int i = ND - 1; i >= 0; i--) idx = idx * 10 + int'(a[4*i +: 4]);
    return IW'(idx);
  endfunction

  function automatic logic valid(input logic [AW-1:0] a);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < ND; i++)
      if (a[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction

  logic cpu_ok, tl_ok;
  assign cpu_ok = valid(cpu_addr_i);
  assign tl_ok  = valid(tl_addr_i);

  // test port wins a same-edge collision
  always_ff @(posedge clk_i) begin
    if (tl_we_i && tl_ok)        mem[to_index(tl_addr_i)]  <= tl_wdata_i;
    else if (cpu_we_i && cpu_ok) mem[to_index(cpu_addr_i)] <= cpu_wdata_i;
  end

  assign cpu_rdata_o = cpu_ok ? mem[to_index(cpu_addr_i)] : '0;
  assign tl_rdata_o  = tl_ok  ? mem[to_index(tl_addr_i)]  : '0;
endmodule

// File: rtl/acc_cpu_top.sv
module acc_cpu_top
  import acc_cpu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tl_we_i,
  input  logic [AW-1:0] tl_addr_i,
  input  logic [W-1:0]  tl_wdata_i,
  output logic [W-1:0]  tl_rdata_o,
  output logic [AW-1:0] pc_o,
  output logic [W-1:0]  ir_o,
  output logic [W-1:0]  acc_o,
  output logic          halted_o
);
  state_e        state;
  logic [AW-1:0] pc, mar, pc_inc;
  logic [W-1:0]  ir, acc, mdr, ram_rdata, alu_out;
  logic          halted, wr;
  logic [3:0]    op;
  logic [AW-1:0] ir_addr;

  assign op      = ir[W-1 -: 4];
  assign ir_addr = ir[AW-1:0];

  assign mar = (state == ST_FETCH) ? pc : ir_addr;
  assign wr  = (state == ST_EXEC) && !halted && (op == OP_STORE);
  assign mdr = wr ? acc : ram_rdata;

  bcd_ram #(.W(W), .AW(AW), .WORDS(MEM_WORDS)) u_ram (
    .clk_i       (clk_i),
    .cpu_addr_i  (mar),
    .cpu_we_i    (wr),
    .cpu_wdata_i (mdr),
    .cpu_rdata_o (ram_rdata),
    .tl_we_i     (tl_we_i),
    .tl_addr_i   (tl_addr_i),
    .tl_wdata_i  (tl_wdata_i),
    .tl_rdata_o  (tl_rdata_o)
  );

  bcd_addsub #(.N(DIGITS)) u_alu (
    .a_i   (acc),
    .b_i   (mdr),
    .sub_i (op == OP_SUB),
    .sum_o (alu_out)
  );

  bcd_addsub #(.N(ADDR_DIGITS)) u_pc_inc (
    .a_i   (pc),
    .b_i   (AW'(1)),
    .sub_i (1'b0),
    .sum_o (pc_inc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_FETCH;
      pc     <= '0;
      ir     <= '0;
      acc    <= '0;
      halted <= 1'b0;
    end else if (!halted) begin
      if (state == ST_FETCH) begin
        ir    <= mdr;
        state <= ST_EXEC;
      end else if (ir == '0) begin
        halted <= 1'b1;          // pc stays on the halt word
      end else begin
        state <= ST_FETCH;
        unique case (op)
          OP_LOAD:         acc <= mdr;
          OP_ADD, OP_SUB:  acc <= alu_out;
          default: ;
        endcase
        pc <= (op == OP_JUMP) ? ir_addr : pc_inc;
      end
    end
  end

  assign pc_o     = pc;
  assign ir_o     = ir;
  assign acc_o    = acc;
  assign halted_o = halted;

  assert_fetch_then_exec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH && !halted) |=> (state == ST_EXEC));
  assert_pc_hold_in_fetch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_FETCH) |=> $stable(pc));
  assert_pc_is_bcd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_is_bcd(pc));
  assert_jump_target_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_EXEC && !halted && op == OP_JUMP) |=> (pc_o == $past(ir_o[AW-1:0])));
  assert_halt_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted |=> (halted && $stable(pc) && $stable(acc) && $stable(ir)));
endmodule

// File: tb/acc_cpu_top_tb_top.sv
module acc_cpu_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 8;

  // {opcode, a, b, expected}
  localparam logic [39:0] VEC [NVEC] = '{
    {4'h3, 12'h123, 12'h456, 12'h579},
    {4'h3, 12'h999, 12'h001, 12'h000},
    {4'h3, 12'h095, 12'h005, 12'h100},
    {4'h3, 12'h358, 12'h647, 12'h005},
    {4'h4, 12'h005, 12'h003, 12'h002},
    {4'h4, 12'h003, 12'h005, 12'h998},
    {4'h4, 12'h100, 12'h001, 12'h099},
    {4'h4, 12'h000, 12'h000, 12'h000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tl_we = 1'b0;
  logic [7:0]  tl_addr = '0;
  logic [11:0] tl_wdata = '0;
  logic [11:0] tl_rdata, ir, acc;
  logic [7:0]  pc;
  logic        halted;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_cpu_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tl_we_i(tl_we), .tl_addr_i(tl_addr),
    .tl_wdata_i(tl_wdata), .tl_rdata_o(tl_rdata), .pc_o(pc), .ir_o(ir),
    .acc_o(acc), .halted_o(halted)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [11:0] d);
    @(negedge clk);
    tl_we = 1'b1; tl_addr = a; tl_wdata = d;
    @(negedge clk);
    tl_we = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [11:0] d);
    tl_addr = a;
    #1;
    d = tl_rdata;
  endtask

  task automatic enter_reset_and_clear();
    @(negedge clk);
    rst_ni = 1'b0;
    for (int t = 0; t < 10; t++)
      for (int u = 0; u < 10; u++) poke({4'(t), 4'(u)}, 12'h000);
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_to_halt(output int cycles);
    cycles = 0;
    while (!halted && cycles < 40) begin
      @(posedge clk); #1;
      cycles++;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [11:0] rd;
    int cyc;

    // R10: reset state, memory kept across reset
    enter_reset_and_clear();
    #1;
    check("R10 pc", 32'(pc), 32'h0);
    check("R10 acc", 32'(acc), 32'h0);
    check("R10 ir", 32'(ir), 32'h0);
    check("R10 halted", 32'(halted), 32'h0);

    // R11: test port write/read and invalid address
    poke(8'h42, 12'h777);
    poke(8'hA0, 12'h555);
    peek(8'h42, rd); check("R11 readback", 32'(rd), 32'h777);
    peek(8'hA0, rd); check("R11 bad addr reads zero", 32'(rd), 32'h0);
    peek(8'h00, rd); check("R11 bad addr no alias", 32'(rd), 32'h0);

    // vector table: R1 R3 R4 R5 R6 R2
    for (int v = 0; v < NVEC; v++) begin
      enter_reset_and_clear();
      poke(8'h00, 12'h110);
      poke(8'h01, {VEC[v][39:36], 8'h11});
      poke(8'h02, 12'h212);
      poke(8'h03, 12'h000);
      poke(8'h10, VEC[v][35:24]);
      poke(8'h11, VEC[v][23:12]);
      release_reset();
      run_to_halt(cyc);
      check(VEC[v][39:36] == 4'h3 ? "R5 add acc" : "R6 sub acc", 32'(acc), 32'(VEC[v][11:0]));
      peek(8'h12, rd);
      check("R4 store result", 32'(rd), 32'(VEC[v][11:0]));
      check("R8 pc at halt", 32'(pc), 32'h03);
      check("R2 cycles to halt", 32'(cyc), 32'd8);
    end

    // R7 jump skips store; R3 load
    enter_reset_and_clear();
    poke(8'h00, 12'h110);
    poke(8'h01, 12'h505);
    poke(8'h02, 12'h212);
    poke(8'h05, 12'h000);
    poke(8'h10, 12'h123);
    release_reset();
    run_to_halt(cyc);
    check("R7 jump pc", 32'(pc), 32'h05);
    check("R3 load acc", 32'(acc), 32'h123);
    peek(8'h12, rd);
    check("R7 skipped store", 32'(rd), 32'h0);
    check("R7 jump cycles", 32'(cyc), 32'd6);
    // R8 freeze
    repeat (10) @(posedge clk);
    #1;
    check("R8 frozen pc", 32'(pc), 32'h05);
    check("R8 frozen acc", 32'(acc), 32'h123);
    check("R8 frozen ir", 32'(ir), 32'h000);
    check("R8 still halted", 32'(halted), 32'h1);

    // R7 wrap 99 -> 00, R9 no-address no-op
    enter_reset_and_clear();
    poke(8'h00, 12'h599);
    poke(8'h99, 12'h001);
    release_reset();
    repeat (2) @(posedge clk);
    #1;
    check("R7 jump to 99", 32'(pc), 32'h99);
    repeat (2) @(posedge clk);
    #1;
    check("R7 wrap to 00", 32'(pc), 32'h00);
    check("R9 no-op acc", 32'(acc), 32'h0);
    check("R9 no-op not halted", 32'(halted), 32'h0);

    // R9 unused opcodes and R1 no-address form
    enter_reset_and_clear();
    poke(8'h00, 12'h110);
    poke(8'h01, 12'h710);
    poke(8'h02, 12'h090);
    poke(8'h03, 12'h000);
    poke(8'h10, 12'h456);
    release_reset();
    run_to_halt(cyc);
    check("R9 acc untouched", 32'(acc), 32'h456);
    check("R9 pc advanced", 32'(pc), 32'h03);
    check("R1 090 not halt", 32'(cyc), 32'd8);
    peek(8'h10, rd);
    check("R9 memory untouched", 32'(rd), 32'h456);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule